// File: doc/BRIEF.md
# Interrupt Enable and Event Latch Unit

This unit is the interrupt section of a host-controlled infrared serial controller. It holds two 8-bit registers that a microcontroller reaches over a small parallel bus: an interrupt mask, and a read-only event register. The bus has an active-low chip select, active-low read and write strobes, a 4-bit register address, and 8-bit write and read data. The transmit and receive datapaths send single-cycle event pulses on bits 0 to 6. The unit derives bit 7, transmitter empty, from three status levels. Each event is latched whether or not its mask bit is set, so the event register also serves as a status register. A read of the event register clears it.

The interrupt line is the OR over all bit positions of (latched event AND mask bit). The host reads the mask at address 1h and the events at address 2h. Software finds the cause by reading the event register, which also acknowledges it. An event pulse that arrives in the same cycle as the acknowledging read is kept for the next read.

The bus is sampled on the system clock. An access acts once, on the first rising clock edge at which its strobe is seen active together with chip select. A strobe held low for several cycles does not repeat the action. Read data is registered at that edge and stays on the read data port until the next read access starts.

Top module: `irq_event_unit`

## Requirements
- R1: The mask register is at address 1h. It is 8 bits wide, can be written and read back, and resets to 00h, so all interrupts are masked after reset.
- R2: The event register is at address 2h and is read-only. A write to address 2h changes neither the event register nor the mask register.
- R3: A pulse on event input bit i (i = 0..6) sets event register bit i at the next clock edge, whatever the value of mask bit i.
- R4: A read of address 2h returns the latched events as they were before the access edge, and clears the event register at that same edge.
- R5: If an event pulse falls on the edge at which a read of address 2h clears the register, that event bit is set after the edge and is returned by the next read.
- R6: Event bit 7 sets at the first edge where send mode, transmit FIFO empty and transmit shift register empty are all high together. It does not set while any of the three is low, and it does not set again while the three stay high after a clearing read.
- R7: irq_o is high exactly when some bit position has both its event bit and its mask bit at 1. It follows the registers without a further delay.
- R8: A read of any address other than 1h and 2h returns 00h and leaves the event register unchanged.
- R9: A read or write acts once, on the first edge at which chip select and its strobe are both low. rdata_o holds the captured value until the next read starts. An access with both strobes low does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| ev_pulse_i | input | 7 | Single-cycle event pulses for event bits 0 to 6 |
| tx_mode_i | input | 1 | Send mode active |
| tx_fifo_empty_i | input | 1 | Transmit FIFO empty |
| tx_shift_empty_i | input | 1 | Transmit shift register empty |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A wrong mask or event bit reaches the ports in two ways. It shows on irq_o in the cycle after the faulty edge, as long as the matching bit on the other side is set. It also shows in the value that the next read of address 1h or 2h returns. A clear that goes missing or comes too early appears on the read after next: that read still returns the old bits, or returns zero where a coincident pulse should have survived. A wrong transmit-empty edge detector either fails to raise bit 7, or raises it again after the acknowledging read while the send conditions are still held, and the next event read shows either error.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_ADDR_W = 4;
  localparam int unsigned IRQ_DATA_W = 8;
  localparam logic [IRQ_ADDR_W-1:0] IRQ_ADDR_MASK  = 4'h1;
  localparam logic [IRQ_ADDR_W-1:0] IRQ_ADDR_EVENT = 4'h2;
endpackage

// File: rtl/irq_bus_strobe.sv
module irq_bus_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_start_o,
  output logic wr_start_o
);
  logic rd_act, wr_act;
  logic rd_act_q, wr_act_q;
  logic rd_act_d, wr_act_d;

  assign rd_act = ~cs_n & ~rd_n & wr_n;
  assign wr_act = ~cs_n & ~wr_n & rd_n;

  always_comb begin
    rd_act_d = rd_act;
    wr_act_d = wr_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q <= 1'b0;
      wr_act_q <= 1'b0;
    end else begin
      rd_act_q <= rd_act_d;
      wr_act_q <= wr_act_d;
    end
  end

  assign rd_start_o = rd_act & ~rd_act_q;
  assign wr_start_o = wr_act & ~wr_act_q;

  // R9
  rd_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start_o |=> !rd_start_o);
  // R9
  wr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start_o |=> !wr_start_o);
endmodule

// File: rtl/irq_txe_detect.sv
module irq_txe_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_mode_i,
  input  logic fifo_empty_i,
  input  logic shift_empty_i,
  output logic set_o
);
  logic cond, cond_q, cond_d;

  assign cond = tx_mode_i & fifo_empty_i & shift_empty_i;

  always_comb cond_d = cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond_d;
  end

  assign set_o = cond & ~cond_q;

  // R6
  txe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_o |=> !set_o);
  // R6
  txe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_mode_i |-> !set_o);
endmodule

// File: rtl/irq_event_latch.sv
module irq_event_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] ev_o
);
  logic [W-1:0] ev_q, ev_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      ev_d[i] = ev_q[i];
      if (clr_i)    ev_d[i] = 1'b0;
      if (set_i[i]) ev_d[i] = 1'b1;
    end

    // R3 R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> ev_o[i]);
    // R4
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i[i]) |=> !ev_o[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= ev_d;
  end

  assign ev_o = ev_q;
endmodule

// File: rtl/irq_event_unit.sv
module irq_event_unit
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W = IRQ_ADDR_W,
  parameter int unsigned DATA_W = IRQ_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-2:0] ev_pulse_i,
  input  logic              tx_mode_i,
  input  logic              tx_fifo_empty_i,
  input  logic              tx_shift_empty_i,
  output logic              irq_o
);
  localparam int unsigned TXE_BIT = DATA_W - 1;

  logic              rd_start, wr_start;
  logic              sel_mask, sel_event;
  logic              txe_set;
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] ev_q;
  logic [DATA_W-1:0] mask_q, mask_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              ev_clr;

  assign sel_mask  = (addr_i == ADDR_W'(IRQ_ADDR_MASK));
  assign sel_event = (addr_i == ADDR_W'(IRQ_ADDR_EVENT));

  irq_bus_strobe u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .rd_start_o (rd_start),
    .wr_start_o (wr_start)
  );

  irq_txe_detect u_txe (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_mode_i     (tx_mode_i),
    .fifo_empty_i  (tx_fifo_empty_i),
    .shift_empty_i (tx_shift_empty_i),
    .set_o         (txe_set)
  );

  assign set_vec = {txe_set, ev_pulse_i};
  assign ev_clr  = rd_start & sel_event;

  irq_event_latch #(.W(DATA_W)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_vec),
    .clr_i (ev_clr),
    .ev_o  (ev_q)
  );

  always_comb begin
    mask_d = mask_q;
    if (wr_start && sel_mask) mask_d = wdata_i;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_start) begin
      if (sel_mask)       rdata_d = mask_q;
      else if (sel_event) rdata_d = ev_q;
      else                rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      mask_q  <= mask_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |(ev_q & mask_q);

  // R1 R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_start && sel_mask) |=> $stable(mask_q));
  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !sel_mask && !sel_event) |=> (rdata_o == '0));
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_start |=> $stable(rdata_o));
  // R7
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_q != '0));
  // R6
  txe_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txe_set |=> ev_q[TXE_BIT]);
endmodule

// File: tb/tb_irq_event_unit.sv
`timescale 1ns/1ps
module tb_irq_event_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, rd_n, wr_n;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [6:0] ev_pulse;
  logic       tx_mode, fifo_e, shift_e;
  logic       irq;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  irq_event_unit dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ev_pulse_i(ev_pulse),
    .tx_mode_i(tx_mode), .tx_fifo_empty_i(fifo_e), .tx_shift_empty_i(shift_e),
    .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic pulse(input logic [6:0] p);
    @(negedge clk);
    ev_pulse = p;
    @(negedge clk);
    ev_pulse = '0;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    cs_n = 1; rd_n = 1; wr_n = 1; addr = 0; wdata = 0; ev_pulse = 0;
    tx_mode = 0; fifo_e = 0; shift_e = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 reset rdata", rdata, 8'h00);
    check("R7 reset irq", {7'd0, irq}, 8'h00);
    bus_read(4'h1, d); check("R1 reset mask", d, 8'h00);
    bus_read(4'h2, d); check("R4 reset events", d, 8'h00);

    // R3 R4 R7 sweep over every mask value
    for (int e = 0; e < 256; e++) begin
      logic [6:0] p;
      p = 7'(((e * 37) + 11) & 8'h7F);
      bus_write(4'h1, 8'(e));
      bus_read(4'h1, d); check("R1 mask readback", d, 8'(e));
      pulse(p);
      check("R7 irq after events", {7'd0, irq}, {7'd0, |({1'b0, p} & 8'(e))});
      bus_read(4'h2, d); check("R3 R4 event read", d, {1'b0, p});
      check("R7 irq after clear", {7'd0, irq}, 8'h00);
      bus_read(4'h2, d); check("R4 cleared", d, 8'h00);
    end

    // R2 write to event address ignored
    bus_write(4'h1, 8'h0F);
    pulse(7'h02);
    bus_write(4'h2, 8'hFF);
    bus_read(4'h1, d); check("R2 mask unchanged", d, 8'h0F);
    bus_read(4'h2, d); check("R2 events unchanged", d, 8'h02);

    // R8 unmapped reads return zero and do not clear
    pulse(7'h41);
    for (int a = 0; a < 16; a++) begin
      if (a == 1 || a == 2) continue;
      bus_read(4'(a), d); check("R8 unmapped read", d, 8'h00);
    end
    check("R7 irq kept", {7'd0, irq}, 8'h01);
    bus_read(4'h2, d); check("R8 events kept", d, 8'h41);

    // R5 set wins over clearing read
    pulse(7'h10);
    @(negedge clk);
    cs_n = 0; rd_n = 0; addr = 4'h2; ev_pulse = 7'h08;
    @(negedge clk);
    d = rdata; cs_n = 1; rd_n = 1; ev_pulse = 0;
    check("R5 read returns old", d, 8'h10);
    check("R5 irq held by new event", {7'd0, irq}, 8'h01);
    bus_read(4'h2, d); check("R5 coincident event kept", d, 8'h08);

    // R9 held read acts once; event during hold survives
    @(negedge clk);
    cs_n = 0; rd_n = 0; addr = 4'h2;
    @(negedge clk);
    ev_pulse = 7'h04;
    @(negedge clk);
    ev_pulse = 0;
    @(negedge clk);
    check("R9 rdata held", rdata, 8'h00);
    cs_n = 1; rd_n = 1;
    bus_read(4'h2, d); check("R9 held read no second clear", d, 8'h04);
    // R9 both strobes low does nothing
    @(negedge clk);
    cs_n = 0; rd_n = 0; wr_n = 0; addr = 4'h1; wdata = 8'hAA;
    @(negedge clk);
    cs_n = 1; rd_n = 1; wr_n = 1;
    bus_read(4'h1, d); check("R9 dual strobe ignored", d, 8'h0F);

    // R6 transmit empty
    bus_write(4'h1, 8'h80);
    @(negedge clk); tx_mode = 1; fifo_e = 1; shift_e = 0;
    @(negedge clk);
    check("R6 no set with shift busy", {7'd0, irq}, 8'h00);
    shift_e = 1;
    @(negedge clk);
    check("R6 irq on empty", {7'd0, irq}, 8'h01);
    bus_read(4'h2, d); check("R6 bit7 set", d, 8'h80);
    repeat (3) @(negedge clk);
    bus_read(4'h2, d); check("R6 no re-set while held", d, 8'h00);
    fifo_e = 0; @(negedge clk); fifo_e = 1;
    @(negedge clk);
    bus_read(4'h2, d); check("R6 re-arm sets", d, 8'h80);
    tx_mode = 0; @(negedge clk); @(negedge clk);
    bus_read(4'h2, d); check("R6 no set outside send mode", d, 8'h00);
    tx_mode = 1; fifo_e = 0; shift_e = 0;

    // R7 masking after latch
    pulse(7'h20);
    check("R7 masked event no irq", {7'd0, irq}, 8'h00);
    bus_write(4'h1, 8'h20);
    check("R7 unmask raises irq", {7'd0, irq}, 8'h01);
    bus_write(4'h1, 8'h00);
    check("R7 mask lowers irq", {7'd0, irq}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule